// File: doc/BRIEF.md
# Period-Aligned PWM Channel Router

This block makes one pulse-width-modulated waveform from the system clock and places it on one of eight output channels. Each channel normally carries its own output-register value, which comes in on `ch_in`. The PWM waveform replaces that value only on the channel that is selected, and only while PWM runs. A second output vector, `pwm_mask`, marks the channel that has been taken over. The neighbouring flash and current-source logic uses this mask to switch itself off on that channel.

Software reaches the block through a simple write port that has two registers.
- The duty register is at `wr_addr` = 1.
- The control register is at `wr_addr` = 0. Its fields are: enable in bit 7, polarity in bit 6, and channel select in bits 2:0.

One period is made of 256 slots of 16 clocks each. A duty value written during a period does not take effect at once. It waits until the next period begins, so the waveform never shows a shortened or stretched cycle. The input `clockless` reports that the slow clock is absent. While it is high, PWM cannot run and every channel passes its normal value through.

Top module: `pwm_router`

## Requirements
- R1: After reset, the duty, enable, polarity and select registers all hold zero. `ch_out` equals `ch_in` one clock later, and `pwm_mask` is zero. If PWM is then enabled without ever writing the duty register, it runs with duty code 00h.
- R2: A period lasts 4096 clocks, made of 256 slots of 16 clocks each. The prescaler and the slot counter both start from zero when PWM starts. The level for slot k (k = 0..255) appears on the selected channel on clocks 16k+1 through 16k+16 after the write edge that starts PWM, and then repeats every 4096 clocks.
- R3: With polarity 0 and a duty code from 01h to FEh, the selected channel is low for (code+1) slots, starting at slot 0. It is high for the remaining (255−code) slots.
- R4: With polarity 1, the levels of R3 are inverted.
- R5: Duty code 00h gives a constant 1 with polarity 0 and a constant 0 with polarity 1. Duty code FFh gives a constant 0 with polarity 0 and a constant 1 with polarity 1.
- R6: A duty write made during a period leaves the rest of that period unchanged. The new value governs the next period, from its first slot onward.
- R7: Control bits 2:0 select the channel that receives the PWM level. Every other channel outputs its `ch_in` bit, delayed by one clock.
- R8: While PWM runs, `pwm_mask` is one-hot on the selected channel. At all other times it is zero.
- R9: After a control write clears enable, the selected channel returns to its `ch_in` value and `pwm_mask` clears, both on the next clock.
- R10: While `clockless` is 1, PWM does not run: every channel passes `ch_in` through and `pwm_mask` stays zero. When `clockless` falls, PWM starts from slot 0 as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 for control, 1 for duty |
| wr_data | input | 8 | Write data |
| clockless | input | 1 | High when the slow clock is absent; blocks PWM |
| ch_in | input | 8 | Normal output-register value of each channel |
| ch_out | output | 8 | Registered per-channel drive value |
| pwm_mask | output | 8 | Marks the channel that PWM has taken over |

## Verification
The hardest case to reach is a duty write that lands in the middle of a running period. To expose it, the write must be placed thousands of clocks away from any period boundary. The output must then be checked against two different duty values, one on each side of the boundary that follows.

The stimulus therefore starts PWM with a known phase and records the cycle of the starting write edge. It then writes a new duty value about a thousand clocks into the period. Finally, it queues per-clock expectations for both periods, indexed by absolute cycle number, so that a change applied too early or too late fails on the exact clock where it goes wrong.

// File: rtl/pwm_router_pkg.sv
package pwm_router_pkg;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_DUTY = 1'b1
    } pwm_addr_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_router_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] duty,
    output logic              enable,
    output logic              polarity,
    output logic [SEL_W-1:0]  sel
);

    localparam int EN_BIT  = DATA_W - 1;
    localparam int POL_BIT = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] duty;
        logic              en;
        logic              pol;
        logic [SEL_W-1:0]  sel;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (pwm_addr_e'(wr_addr) == ADDR_DUTY) begin
                regs_d.duty = wr_data;
            end else begin
                regs_d.en  = wr_data[EN_BIT];
                regs_d.pol = wr_data[POL_BIT];
                regs_d.sel = wr_data[SEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign duty     = regs_q.duty;
    assign enable   = regs_q.en;
    assign polarity = regs_q.pol;
    assign sel      = regs_q.sel;

    // R6: a duty write from the port is visible in the duty register one clock later
    a_r6_duty_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 1'b1) |=> duty == $past(wr_data));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DUTY_W    = 8,
    parameter int SLOT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DUTY_W-1:0] duty,
    input  logic              pol,
    output logic              lvl
);

    localparam int PRE_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_CLKS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] slot;
        logic [DUTY_W-1:0] shadow;
    } tb_t;

    tb_t tb_d, tb_q;
    logic              at_start;
    logic [DUTY_W-1:0] code;
    logic              base;

    always_comb begin
        tb_d     = tb_q;
        at_start = (tb_q.pre == '0) && (tb_q.slot == '0);
        code     = at_start ? duty : tb_q.shadow;
        tb_d.shadow = code;

        if (!run) begin
            tb_d.pre  = '0;
            tb_d.slot = '0;
        end else if (tb_q.pre == PRE_LAST) begin
            tb_d.pre  = '0;
            tb_d.slot = tb_q.slot + 1'b1;
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
        end

        if (code == '0)      base = 1'b1;
        else if (&code)      base = 1'b0;
        else                 base = (tb_q.slot <= code) ? 1'b0 : 1'b1;
        lvl = base ^ pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    // R2: the slot counter steps by one when a running slot ends
    a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
        run && (tb_q.pre == PRE_LAST) |=> tb_q.slot == $past(tb_q.slot) + DUTY_W'(1));

    // R2: counters sit at zero while stopped, so a start begins at slot 0
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tb_q.pre == '0) && (tb_q.slot == '0));

    // R6: the applied duty only changes at a period start
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !at_start |=> $stable(tb_q.shadow));

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [SEL_W-1:0]  sel,
    input  logic              lvl,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_CH-1:0] mask
);

    typedef struct packed {
        logic [NUM_CH-1:0] out;
        logic [NUM_CH-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            st_d.mask[i] = run && (sel == SEL_W'(i));
            st_d.out[i]  = st_d.mask[i] ? lvl : ch_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_out = st_q.out;
    assign mask   = st_q.mask;

    // R8: at most one channel is ever claimed
    a_r8_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.mask));

    // R8: the claimed channel follows the select while running
    a_r8_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> st_q.mask == (NUM_CH'(1) << $past(sel)));

    // R9: no channel stays claimed once PWM stops
    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.mask == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R7: unselected channels pass their input with one clock of delay
        a_r7_unselected_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (!run || (sel != SEL_W'(g))) |=> ch_out[g] == $past(ch_in[g]));
    end

endmodule

// File: rtl/pwm_router.sv
module pwm_router #(
    parameter int NUM_CH    = 8,
    parameter int DUTY_W    = 8,
    parameter int SLOT_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    input  logic              clockless,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_CH-1:0] pwm_mask
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [DUTY_W-1:0] duty;
    logic              enable;
    logic              polarity;
    logic [SEL_W-1:0]  sel;
    logic              run;
    logic              lvl;

    pwm_regs #(.DATA_W(DUTY_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .duty     (duty),
        .enable   (enable),
        .polarity (polarity),
        .sel      (sel)
    );

    assign run = enable && !clockless;

    pwm_timebase #(.DUTY_W(DUTY_W), .SLOT_CLKS(SLOT_CLKS)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .duty  (duty),
        .pol   (polarity),
        .lvl   (lvl)
    );

    pwm_steer #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sel    (sel),
        .lvl    (lvl),
        .ch_in  (ch_in),
        .ch_out (ch_out),
        .mask   (pwm_mask)
    );

    // R10: with the slow clock absent no channel is claimed
    a_r10_clockless_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clockless |=> pwm_mask == '0);

endmodule

// File: tb/test_pwm_router.sv
module test_pwm_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clockless = 1'b0;
    logic [7:0] ch_in = 8'hA5;
    logic [7:0] ch_out;
    logic [7:0] pwm_mask;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         cyc;
        logic [7:0] out;
        logic [7:0] mask;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;

    pwm_router i_pwm_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clockless (clockless),
        .ch_in     (ch_in),
        .ch_out    (ch_out),
        .pwm_mask  (pwm_mask)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: compares queued expectations on the matching cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            mon_e = q.pop_front();
            checks++;
            if (mon_e.cyc != cyc || ch_out !== mon_e.out || pwm_mask !== mon_e.mask) begin
                errors++;
                $display("FAIL %s cyc %0d: out %h mask %h, expected out %h mask %h (for cyc %0d)",
                         mon_e.tag, cyc, ch_out, pwm_mask, mon_e.out, mon_e.mask, mon_e.cyc);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        report();
        $finish;
    end

    function automatic logic lvl_of(int t, logic [7:0] code, logic pol);
        int  slot;
        logic b;
        slot = t / 16;
        if (code == 8'h00)      b = 1'b1;
        else if (code == 8'hFF) b = 1'b0;
        else                    b = (slot <= int'(code)) ? 1'b0 : 1'b1;
        return b ^ pol;
    endfunction

    function automatic logic [7:0] exp_vec(logic [7:0] pass, int s, logic v);
        logic [7:0] r;
        r = pass;
        r[s] = v;
        return r;
    endfunction

    task automatic push_item(int c, logic [7:0] o, logic [7:0] m, string tag);
        exp_t e;
        e.cyc = c; e.out = o; e.mask = m; e.tag = tag;
        q.push_back(e);
    endtask

    // driver: expectations for period k after a start edge c0
    task automatic push_period(int c0, int k, logic [7:0] code, logic pol, int s,
                               logic [7:0] pass, string tag);
        for (int t = 0; t < 4096; t++) begin
            push_item(c0 + 4096 * k + t + 1, exp_vec(pass, s, lvl_of(t, code, pol)),
                      8'(1) << s, tag);
        end
    endtask

    task automatic push_const(int cstart, int n, logic [7:0] o, logic [7:0] m, string tag);
        for (int i = 0; i < n; i++) push_item(cstart + i, o, m, tag);
    endtask

    task automatic wait_cyc(int target);
        while (cyc < target) @(negedge clk);
    endtask

    // returns the cycle count that includes the write edge
    task automatic wr(logic a, logic [7:0] d, output int c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        c = cyc;
    endtask

    task automatic stop_pwm(logic [7:0] pass);
        int cd;
        wr(1'b0, 8'h00, cd);
        push_const(cd + 1, 8, pass, 8'h00, "R9 release after enable cleared");
        wait_cyc(cd + 10);
    endtask

    task automatic run_case(logic [7:0] code, logic pol, int s, logic [7:0] pass, string tag);
        int c0, cw;
        wr(1'b1, code, cw);
        wr(1'b0, {1'b1, pol, 3'b000, 3'(s)}, c0);
        push_period(c0, 0, code, pol, s, pass, tag);
        wait_cyc(c0 + 4097);
        stop_pwm(pass);
    endtask

    initial begin
        int c0, cw, cx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, pass-through, no claim
        push_const(cyc + 1, 6, 8'hA5, 8'h00, "R1 reset pass-through");
        wait_cyc(cyc + 8);

        // R1 R5: enable without writing duty -> code 00h, polarity 0 -> constant 1
        wr(1'b0, 8'h82, c0);
        push_period(c0, 0, 8'h00, 1'b0, 2, 8'hA5, "R1 R5 R2 reset duty 00h");
        wait_cyc(c0 + 4097);
        stop_pwm(8'hA5);

        // R2 R3 R7 R8 then R6: mid-period duty write deferred
        ch_in = 8'h5A;
        @(negedge clk);
        wr(1'b1, 8'h40, cw);
        wr(1'b0, 8'h83, c0);
        push_period(c0, 0, 8'h40, 1'b0, 3, 8'h5A, "R2 R3 R7 R8 duty 40h");
        wait_cyc(c0 + 1000);
        wr(1'b1, 8'h10, cw);
        push_period(c0, 1, 8'h10, 1'b0, 3, 8'h5A, "R6 deferred duty 10h");
        wait_cyc(c0 + 8193);
        stop_pwm(8'h5A);

        // R4 then R6 with polarity inverted
        wr(1'b1, 8'h80, cw);
        wr(1'b0, 8'hC7, c0);
        push_period(c0, 0, 8'h80, 1'b1, 7, 8'h5A, "R4 inverted duty 80h");
        wait_cyc(c0 + 2000);
        wr(1'b1, 8'hFE, cw);
        push_period(c0, 1, 8'hFE, 1'b1, 7, 8'h5A, "R4 R6 inverted duty FEh");
        wait_cyc(c0 + 8193);
        stop_pwm(8'h5A);

        // R5 constant codes, R3 smallest low time
        ch_in = 8'h3C;
        @(negedge clk);
        run_case(8'hFF, 1'b0, 0, 8'h3C, "R5 code FFh polarity 0");
        run_case(8'h00, 1'b1, 5, 8'h3C, "R5 code 00h polarity 1");
        run_case(8'hFF, 1'b1, 1, 8'h3C, "R5 code FFh polarity 1");
        run_case(8'h01, 1'b0, 4, 8'h3C, "R3 code 01h two low slots");

        // R10: slow clock absent blocks PWM, release starts at slot 0
        wr(1'b1, 8'h20, cw);
        @(negedge clk);
        clockless = 1'b1;
        wr(1'b0, 8'h86, cx);
        push_const(cx + 1, 100, 8'h3C, 8'h00, "R10 clockless pass-through");
        wait_cyc(cx + 102);
        clockless = 1'b0;
        cx = cyc;
        push_period(cx, 0, 8'h20, 1'b0, 6, 8'h3C, "R10 R2 start after clock returns");
        wait_cyc(cx + 4097);
        stop_pwm(8'h3C);

        wait_cyc(cyc + 2);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 queue not drained: actual %0d left, expected 0", q.size());
        end
        report();
        $finish;
    end

endmodule